// File: doc/BRIEF.md
# Fourth-Order Decimating Filter for a 1-Bit Modulator Stream

This block turns the single-bit output of a delta-sigma modulator into 20-bit two's complement conversion words. Every enabled modulator sample passes through four cascaded accumulators. Once per decimation period, four cascaded differencing stages form the filtered value. That value is then shifted down and clipped to 20 bits. The decimation period can be changed at run time: 960 samples for the fast rate or 7680 samples for the slow rate. With a 64-to-1 modulator enable, this gives one word every 61,440 or 491,520 master clocks.

Each finished word comes with a strobe that is one clock wide. A settled flag stays low after any restart until the filter's whole impulse window is covered by real samples, which is the fourth result. A change of the speed select and a pulse on the synchronous restart input both flush all filter state and start that count again. The scaling is the same for both rates: a stream of all ones lies beyond positive full scale and is clipped.

Top module: `sinc4_decim`

## Requirements
- R1: A modulator bit of 1 counts as +1 and a bit of 0 counts as -1. From the fourth result after a restart, a constant 1 stream gives 7FFFFh and a constant 0 stream gives 80000h, because the output clips at these two codes.
- R2: With speed_sel = 1, exactly 960 enabled samples separate consecutive result strobes; with speed_sel = 0, exactly 7680. A strobe appears in the cycle after the enabled sample that completes a period.
- R3: result_valid_o is never high in two consecutive cycles.
- R4: After a reset, restart or speed change, settled_o is low together with the first three result strobes. It goes high together with the fourth strobe and stays high until the next flush.
- R5: An alternating 1,0 stream (zero mean) gives 00000h from the fourth result on.
- R6: At both rates the unclipped scale is ±810000 codes per unit mean. A stream with one 1 in every four samples gives 9D1F8h, and a stream with three 1s in every four gives 62E08h, from the fourth result on.
- R7: While mod_ce is low, mod_bit has no effect and no sample is counted.
- R8: restart clears all filter state, result_o, result_valid_o and settled_o on the next edge. The sample offered in that cycle is discarded.
- R9: A change of speed_sel flushes the filter like restart. The new ratio applies from the next sample.
- R10: During and after reset, result_o = 0, result_valid_o = 0 and settled_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_ce | input | 1 | Modulator sample enable |
| mod_bit | input | 1 | Modulator output bit |
| speed_sel | input | 1 | 1 = ratio 960, 0 = ratio 7680 |
| restart | input | 1 | Synchronous flush of all filter state |
| result_o | output | 20 | Two's complement conversion word |
| result_valid_o | output | 1 | One-cycle strobe per new word |
| settled_o | output | 1 | Filter window fully covered since last flush |

## Verification
On every cycle, the assertions check that the strobe is one clock wide and that the sample counter stays inside the current period. They also check that settled_o can only rise together with a strobe, and that restart or a speed change clears the accumulators, the delay stages and the outputs. Only the directed scenarios can show the arithmetic: the clipped full-scale codes, the exact zero and ±405000 results from periodic streams at both ratios, the count of enabled samples between strobes, and that mod_bit has no effect while mod_ce is low.

// File: rtl/sinc4_pkg.sv
package sinc4_pkg;
    // speed select encoding: fast ratio when high
    typedef enum logic {
        RATE_SLOW = 1'b0,
        RATE_FAST = 1'b1
    } rate_e;
endpackage

// File: rtl/sinc_integ.sv
module sinc_integ #(
    parameter int W = 53,
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         ce,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum_o
);
    typedef struct packed {
        logic [N-1:0][W-1:0] acc;
    } integ_t;

    integ_t st_d, st_q;
    logic [W-1:0] tap [N+1];

    assign tap[0] = din;
    generate
        for (genvar k = 0; k < N; k++) begin : g_stage
            assign tap[k+1] = st_q.acc[k] + tap[k];
        end
    endgenerate

    // value of the last stage including the present sample
    assign sum_o = tap[N];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (ce) begin
            for (int k = 0; k < N; k++) begin
                st_d.acc[k] = tap[k+1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_integ_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q == '0));
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
    parameter int W = 53,
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    typedef struct packed {
        logic [N-1:0][W-1:0] dly;
    } comb_t;

    comb_t st_d, st_q;
    logic [W-1:0] diff [N+1];

    assign diff[0] = x;
    generate
        for (genvar k = 0; k < N; k++) begin : g_stage
            assign diff[k+1] = diff[k] - st_q.dly[k];
        end
    endgenerate

    assign y = diff[N];

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (load) begin
            for (int k = 0; k < N; k++) begin
                st_d.dly[k] = diff[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_comb_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q == '0));
endmodule

// File: rtl/sinc_outreg.sv
module sinc_outreg #(
    parameter int W       = 53,
    parameter int OUT_W   = 20,
    parameter int SH_SLOW = 32,
    parameter int SH_FAST = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             fast,
    input  logic             full_i,
    input  logic [W-1:0]     y,
    output logic [OUT_W-1:0] result_o,
    output logic             valid_o,
    output logic             settled_o
);
    localparam logic signed [W-1:0] MAX_V = W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
    localparam logic signed [W-1:0] MIN_V = -MAX_V - W'(1);

    typedef struct packed {
        logic [OUT_W-1:0] res;
        logic             vld;
        logic             set;
    } out_t;

    out_t st_d, st_q;
    logic signed [W-1:0] ys;
    logic signed [W-1:0] shv;
    logic [OUT_W-1:0]    clipped;

    assign ys  = $signed(y);
    assign shv = fast ? (ys >>> SH_FAST) : (ys >>> SH_SLOW);

    always_comb begin
        if (shv > MAX_V)      clipped = MAX_V[OUT_W-1:0];
        else if (shv < MIN_V) clipped = MIN_V[OUT_W-1:0];
        else                  clipped = shv[OUT_W-1:0];
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clr) begin
            st_d = '0;
        end else if (load) begin
            st_d.res = clipped;
            st_d.vld = 1'b1;
            st_d.set = full_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o  = st_q.res;
    assign valid_o   = st_q.vld;
    assign settled_o = st_q.set;

    p_result_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr) |=> $stable(result_o));
endmodule

// File: rtl/sinc4_decim.sv
module sinc4_decim
    import sinc4_pkg::*;
#(
    parameter int ORDER  = 4,
    parameter int R_SLOW = 7680,
    parameter int R_FAST = 960,
    parameter int OUT_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_ce,
    input  logic             mod_bit,
    input  logic             speed_sel,
    input  logic             restart,
    output logic [OUT_W-1:0] result_o,
    output logic             result_valid_o,
    output logic             settled_o
);
    localparam int LOG_SLOW = $clog2(R_SLOW);
    localparam int LOG_FAST = $clog2(R_FAST);
    localparam int ACC_W    = ORDER * LOG_SLOW + 1;
    localparam int CNT_W    = LOG_SLOW;
    localparam int SET_W    = $clog2(ORDER + 1);
    localparam int SH_SLOW  = ORDER * LOG_SLOW - OUT_W;
    localparam int SH_FAST  = ORDER * LOG_FAST - OUT_W;
    localparam logic [CNT_W-1:0] LAST_SLOW = CNT_W'(R_SLOW - 1);
    localparam logic [CNT_W-1:0] LAST_FAST = CNT_W'(R_FAST - 1);
    localparam logic [SET_W-1:0] SET_FULL  = SET_W'(ORDER);

    typedef struct packed {
        rate_e            speed;
        logic [CNT_W-1:0] cnt;
        logic [SET_W-1:0] settle;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic             clr;
    logic             sample;
    logic             last;
    logic [CNT_W-1:0] last_idx;
    logic [ACC_W-1:0] din;
    logic [ACC_W-1:0] isum;
    logic [ACC_W-1:0] cy;

    assign clr      = restart || (rate_e'(speed_sel) != ctl_q.speed);
    assign sample   = mod_ce && !clr;
    assign last_idx = (ctl_q.speed == RATE_FAST) ? LAST_FAST : LAST_SLOW;
    assign last     = sample && (ctl_q.cnt == last_idx);
    assign din      = mod_bit ? ACC_W'(1) : {ACC_W{1'b1}};

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.speed = rate_e'(speed_sel);
        if (clr) begin
            ctl_d.cnt    = '0;
            ctl_d.settle = '0;
        end else if (sample) begin
            if (last) begin
                ctl_d.cnt = '0;
                if (ctl_q.settle != SET_FULL) ctl_d.settle = ctl_q.settle + SET_W'(1);
            end else begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.speed  <= RATE_SLOW;
            ctl_q.cnt    <= '0;
            ctl_q.settle <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sinc_integ #(.W(ACC_W), .N(ORDER)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .ce    (sample),
        .din   (din),
        .sum_o (isum)
    );

    sinc_comb #(.W(ACC_W), .N(ORDER)) u_comb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .load  (last),
        .x     (isum),
        .y     (cy)
    );

    sinc_outreg #(.W(ACC_W), .OUT_W(OUT_W), .SH_SLOW(SH_SLOW), .SH_FAST(SH_FAST)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .load      (last),
        .fast      (ctl_q.speed == RATE_FAST),
        .full_i    (ctl_d.settle == SET_FULL),
        .y         (cy),
        .result_o  (result_o),
        .valid_o   (result_valid_o),
        .settled_o (settled_o)
    );

    p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.cnt <= last_idx);

    p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |=> !result_valid_o);

    p_settle_with_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled_o) |-> result_valid_o);

    p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!settled_o && !result_valid_o && result_o == '0));

    p_speed_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_e'(speed_sel) != ctl_q.speed) |=> (!settled_o && !result_valid_o));
endmodule

// File: tb/sim_sinc4_decim.sv
module sim_sinc4_decim;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_ce = 1'b0;
    logic        mod_bit = 1'b0;
    logic        speed_sel = 1'b1;
    logic        restart = 1'b0;
    logic [19:0] result_o;
    logic        result_valid_o;
    logic        settled_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    sinc4_decim u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .mod_ce         (mod_ce),
        .mod_bit        (mod_bit),
        .speed_sel      (speed_sel),
        .restart        (restart),
        .result_o       (result_o),
        .result_valid_o (result_valid_o),
        .settled_o      (settled_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // kind: 0 all ones, 1 all zeros, 2 alternating, 3 one-in-four, 4 three-in-four
    function automatic logic pat(input int kind, input int idx);
        case (kind)
            0: return 1'b1;
            1: return 1'b0;
            2: return (idx % 2 == 0);
            3: return (idx % 4 == 0);
            default: return (idx % 4 != 3);
        endcase
    endfunction

    task automatic collect(input int kind, input int nres, input bit gappy, input int ratio,
                           output logic [19:0] last_res, output int sp_bad,
                           output int set_bad, output int wid_bad);
        int got = 0;
        int idx = 0;
        int since = 0;
        int cyc = 0;
        bit prev_v = 1'b0;
        sp_bad = 0; set_bad = 0; wid_bad = 0; last_res = '0;
        while (got < nres) begin
            @(negedge clk);
            if (result_valid_o) begin
                got++;
                if (prev_v) wid_bad++;
                if (since != ratio) sp_bad++;
                if (settled_o != (got >= 4)) set_bad++;
                since = 0;
                last_res = result_o;
            end else if (settled_o != (got >= 4)) begin
                set_bad++;
            end
            prev_v = result_valid_o;
            if (gappy && (cyc % 3 != 0)) begin
                mod_ce  = 1'b0;
                mod_bit = ~pat(kind, idx);
            end else begin
                mod_ce  = 1'b1;
                mod_bit = pat(kind, idx);
                idx++;
                since++;
            end
            cyc++;
        end
        @(negedge clk);
        if (result_valid_o) wid_bad++;
        mod_ce = 1'b0;
    endtask

    task automatic do_restart();
        @(negedge clk);
        mod_ce  = 1'b0;
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        chk(!settled_o && !result_valid_o && result_o == 20'h0, "R8 restart flush",
            {settled_o, result_valid_o, result_o}, 0);
    endtask

    task automatic run_case(input int kind, input bit gappy, input int ratio,
                            input logic [19:0] exp, input string req);
        logic [19:0] r;
        int sp, st, wd;
        do_restart();
        collect(kind, 5, gappy, ratio, r, sp, st, wd);
        chk(r == exp, req, r, exp);
        chk(sp == 0, "R2 enabled samples per strobe", sp, 0);
        chk(st == 0, "R4 settled on fourth result", st, 0);
        chk(wd == 0, "R3 one-cycle strobe", wd, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(result_o == 0 && !result_valid_o && !settled_o, "R10 reset state",
            {settled_o, result_valid_o, result_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(result_o == 0 && !result_valid_o && !settled_o, "R10 after release",
            {settled_o, result_valid_o, result_o}, 0);
    endtask

    task automatic t_fullscale();
        run_case(0, 1'b0, 960, 20'h7FFFF, "R1 ones clip positive");
        chk(settled_o == 1'b1, "R4 settled held", settled_o, 1);
        run_case(1, 1'b0, 960, 20'h80000, "R1 zeros clip negative");
    endtask

    task automatic t_zero();
        run_case(2, 1'b0, 960, 20'h00000, "R5 alternating gives zero");
    endtask

    task automatic t_fraction();
        run_case(3, 1'b0, 960, 20'h9D1F8, "R6 quarter density fast");
        run_case(4, 1'b0, 960, 20'h62E08, "R6 three-quarter density fast");
    endtask

    task automatic t_gaps();
        run_case(3, 1'b1, 960, 20'h9D1F8, "R7 idle bits ignored");
    endtask

    task automatic t_speed();
        logic [19:0] r;
        int sp, st, wd;
        @(negedge clk);
        mod_ce    = 1'b0;
        speed_sel = 1'b0;
        @(negedge clk);
        chk(!settled_o && !result_valid_o, "R9 speed change flush", settled_o, 0);
        collect(4, 5, 1'b0, 7680, r, sp, st, wd);
        chk(r == 20'h62E08, "R6 three-quarter density slow", r, 20'h62E08);
        chk(sp == 0, "R9 R2 slow ratio 7680", sp, 0);
        chk(st == 0, "R9 R4 settle recount", st, 0);
        chk(wd == 0, "R3 one-cycle strobe slow", wd, 0);
    endtask

    initial begin
        t_reset();
        t_fullscale();
        t_zero();
        t_fraction();
        t_gaps();
        t_speed();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule